// File: doc/BRIEF.md
# Strap Capture and Power-Down Sequencer

This block sits between a board-level power-good pin and the clock output stages of a clock generator. While the supply is coming up, four configuration straps are presented to it. Three pick the CPU frequency and one picks which of two decode tables applies. The straps are sampled exactly once, on the first synchronized low level of the power-good pin. From then on the block ignores the straps and treats the same pin as an active-high power-down request.

A power-down request is synchronized and then qualified on two consecutive clock edges before it takes effect. Each output class has its own divided clock, and its state changes only on a falling edge of that clock. In power-down the single-ended class is held low. Each differential class is either held with its true leg high and its complement undriven, or has both legs tri-stated, as chosen by a drive-mode bit. When the request is withdrawn, a lock-delay counter models PLL settling before the outputs run again. The captured strap bits stay available for register readback.

Top module: `strap_pd_seq`

## Requirements
- R1: After reset `pd_active` is 0, every class state is run (code 0) and `strap_rb` is 0000.
- R2: The first time the power-good pin is seen low after two synchronizer flops, the straps are latched into `strap_rb` as bit 3 = table select, bit 2 = FS_C, bit 1 = FS_B, bit 0 = FS_A. The latch happens on the third rising edge after the pin falls.
- R3: Once the straps are latched, further changes on the straps or the pin never alter `strap_rb`.
- R4: With table select 0, {FS_C,FS_B,FS_A} decodes as 101→code 0 (100 MHz), 001→code 1 (133 MHz), 010→code 2 (200 MHz) and 000→code 3 (266 MHz). Every other value sets `freq_rsvd` and gives code 0.
- R5: With table select 1, {FS_B,FS_A} decodes as 00→code 0, 01→code 1 and 10→code 2, and FS_C has no effect. The value 11 sets `freq_rsvd` and gives code 0.
- R6: A pin that goes high before rising edge k makes `pd_active` go to 1 at edge k+3, because the synchronized level must be high on two consecutive edges. A high pulse lasting a single cycle is ignored.
- R7: A class state changes only on a falling edge of that class's clock. The single-ended class moves to code 1 (held low) in power-down, and its clock output then reads 0.
- R8: In power-down, a differential class whose drive-mode bit is 0 goes to code 2: true leg 1 and driven, complement undriven. A class whose bit is 1 goes to code 3: both legs undriven.
- R9: A pin that goes low before edge k clears `pd_active` at edge k+LOCK_TICKS+2. A request that qualifies on the same edge the lock delay expires keeps `pd_active` at 1.
- R10: Before the straps are latched, a high level on the pin never sets `pd_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pd_pin | input | 1 | Power-good (active low), then power-down request (active high) |
| strap_fa | input | 1 | Frequency strap A |
| strap_fb | input | 1 | Frequency strap B |
| strap_fc | input | 1 | Frequency strap C |
| strap_tbl | input | 1 | Decode-table select strap |
| pd_tri_mode | input | N_DIFF | Per differential class: 1 = tri-state in power-down |
| freq_code | output | 2 | Decoded CPU frequency code |
| freq_rsvd | output | 1 | Strap combination is reserved |
| strap_rb | output | 4 | Latched straps for readback |
| pd_active | output | 1 | Power-down in force or lock delay pending |
| se_clk | output | 1 | Single-ended class clock output |
| se_state | output | 2 | Single-ended class state code |
| diff_t | output | N_DIFF | Differential true legs |
| diff_c | output | N_DIFF | Differential complement legs |
| diff_t_oe | output | N_DIFF | True-leg drive enables |
| diff_c_oe | output | N_DIFF | Complement-leg drive enables |
| diff_state | output | 2*N_DIFF | Differential class state codes, two bits per class |

## Verification
Two events can land on the same edge. One is the lock-delay counter reaching its end. The other is a fresh power-down request completing its two-edge qualification. The bench withdraws the request and then raises it again exactly LOCK_TICKS-1 cycles later, so that both events fall on one edge. It then requires `pd_active` to stay high through the whole window. The bench also changes the drive-mode bits while power-down is in force, so that a new target state meets a class's falling-edge decision point. A behavioural model compares every class state and pin on every clock.

// File: rtl/strap_pd_pkg.sv
package strap_pd_pkg;

    typedef enum logic [1:0] {
        FQ_100 = 2'd0,
        FQ_133 = 2'd1,
        FQ_200 = 2'd2,
        FQ_266 = 2'd3
    } freq_e;

    typedef enum logic [1:0] {
        OST_RUN  = 2'd0,
        OST_LOW  = 2'd1,
        OST_HIGH = 2'd2,
        OST_TRI  = 2'd3
    } ostate_e;

    typedef enum logic [1:0] {
        SQ_RUN  = 2'd0,
        SQ_PD   = 2'd1,
        SQ_LOCK = 2'd2
    } seq_e;

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_lo_i,
    input  logic       fa_i,
    input  logic       fb_i,
    input  logic       fc_i,
    input  logic       tbl_i,
    output logic       captured_o,
    output logic [3:0] rb_o,
    output freq_e      freq_o,
    output logic       rsvd_o
);

    typedef struct packed {
        logic       cap;
        logic [3:0] bits;
    } cap_s;

    cap_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!r_q.cap && sync_lo_i) begin
            r_d.cap  = 1'b1;
            r_d.bits = {tbl_i, fc_i, fb_i, fa_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // decode of the latched straps, table chosen by bit 3
    always_comb begin
        freq_o = FQ_100;
        rsvd_o = 1'b0;
        if (!r_q.bits[3]) begin
            case (r_q.bits[2:0])
                3'b101:  freq_o = FQ_100;
                3'b001:  freq_o = FQ_133;
                3'b010:  freq_o = FQ_200;
                3'b000:  freq_o = FQ_266;
                default: rsvd_o = 1'b1;
            endcase
        end else begin
            case (r_q.bits[1:0])
                2'b00:   freq_o = FQ_100;
                2'b01:   freq_o = FQ_133;
                2'b10:   freq_o = FQ_200;
                default: rsvd_o = 1'b1;
            endcase
        end
    end

    assign captured_o = r_q.cap;
    assign rb_o       = r_q.bits;

endmodule

// File: rtl/pd_qualifier.sv
module pd_qualifier
    import strap_pd_pkg::*;
#(
    parameter int LOCK_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic captured_i,
    output logic sync_lo_o,
    output logic pd_active_o
);

    localparam int LW = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS + 1) : 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          seen;
        seq_e          st;
        logic [LW-1:0] cnt;
    } q_s;

    q_s   r_q, r_d;
    logic req, qual;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = pin_i;
        r_d.s2   = r_q.s1;
        req      = captured_i & r_q.s2;
        qual     = req & r_q.seen;
        r_d.seen = req;
        case (r_q.st)
            SQ_RUN: begin
                if (qual) r_d.st = SQ_PD;
            end
            SQ_PD: begin
                if (!r_q.s2) begin
                    r_d.st  = SQ_LOCK;
                    r_d.cnt = LW'(LOCK_TICKS - 1);
                end
            end
            SQ_LOCK: begin
                if (qual)               r_d.st  = SQ_PD;
                else if (r_q.cnt == '0) r_d.st  = SQ_RUN;
                else                    r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.st = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.s1   <= 1'b1;
            r_q.s2   <= 1'b1;
            r_q.st   <= SQ_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_lo_o   = ~r_q.s2;
    assign pd_active_o = (r_q.st != SQ_RUN);

endmodule

// File: rtl/class_gate.sv
module class_gate
    import strap_pd_pkg::*;
#(
    parameter int DIV = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ostate_e want_i,
    output ostate_e state_o,
    output logic    ph_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
        ostate_e       st;
    } g_s;

    g_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == CW'(DIV - 1)) begin
            r_d.cnt = '0;
            r_d.ph  = ~r_q.ph;
            if (r_q.ph) r_d.st = want_i;   // decided on the falling edge only
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
            r_q.ph  <= 1'b0;
            r_q.st  <= OST_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign ph_o    = r_q.ph;

endmodule

// File: rtl/strap_pd_seq.sv
module strap_pd_seq
    import strap_pd_pkg::*;
#(
    parameter int N_DIFF     = 2,
    parameter int LOCK_TICKS = 8,
    parameter int DIFF_DIV   = 1,
    parameter int SE_DIV     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pg_pd_pin,
    input  logic                strap_fa,
    input  logic                strap_fb,
    input  logic                strap_fc,
    input  logic                strap_tbl,
    input  logic [N_DIFF-1:0]   pd_tri_mode,
    output logic [1:0]          freq_code,
    output logic                freq_rsvd,
    output logic [3:0]          strap_rb,
    output logic                pd_active,
    output logic                se_clk,
    output logic [1:0]          se_state,
    output logic [N_DIFF-1:0]   diff_t,
    output logic [N_DIFF-1:0]   diff_c,
    output logic [N_DIFF-1:0]   diff_t_oe,
    output logic [N_DIFF-1:0]   diff_c_oe,
    output logic [2*N_DIFF-1:0] diff_state
);

    logic    captured;
    logic    sync_lo;
    logic    pd_int;
    freq_e   freq_int;
    ostate_e se_want, se_st;
    logic    se_ph;

    strap_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_lo_i  (sync_lo),
        .fa_i       (strap_fa),
        .fb_i       (strap_fb),
        .fc_i       (strap_fc),
        .tbl_i      (strap_tbl),
        .captured_o (captured),
        .rb_o       (strap_rb),
        .freq_o     (freq_int),
        .rsvd_o     (freq_rsvd)
    );

    pd_qualifier #(.LOCK_TICKS(LOCK_TICKS)) u_pdq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pg_pd_pin),
        .captured_i  (captured),
        .sync_lo_o   (sync_lo),
        .pd_active_o (pd_int)
    );

    assign freq_code = freq_int;
    assign pd_active = pd_int;

    assign se_want = pd_int ? OST_LOW : OST_RUN;

    class_gate #(.DIV(SE_DIV)) u_se (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (se_want),
        .state_o (se_st),
        .ph_o    (se_ph)
    );

    assign se_clk   = (se_st == OST_RUN) & se_ph;
    assign se_state = se_st;

    for (genvar gi = 0; gi < N_DIFF; gi++) begin : g_diff
        ostate_e want, st;
        logic    ph;

        assign want = !pd_int        ? OST_RUN :
                      pd_tri_mode[gi] ? OST_TRI : OST_HIGH;

        class_gate #(.DIV(DIFF_DIV)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_i  (want),
            .state_o (st),
            .ph_o    (ph)
        );

        assign diff_t[gi]          = (st == OST_RUN) ? ph : (st == OST_HIGH);
        assign diff_c[gi]          = (st == OST_RUN) & ~ph;
        assign diff_t_oe[gi]       = (st != OST_TRI);
        assign diff_c_oe[gi]       = (st == OST_RUN);
        assign diff_state[2*gi +: 2] = st;
    end

endmodule

// File: rtl/strap_pd_seq_chk.sv
module strap_pd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       captured,
    input logic       sync_lo,
    input logic [3:0] strap_rb,
    input logic       pd_active,
    input logic [1:0] se_state,
    input logic       se_ph
);

    // R2: nothing is latched before the capture event
    p_rb_clear_before_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !captured |-> strap_rb == 4'd0);

    // R3: latched straps never move again
    p_rb_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && $past(captured)) |-> $stable(strap_rb));

    // R6: power-down needs two consecutive synchronized high samples
    p_two_edge_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> (!$past(sync_lo) && !$past(sync_lo, 2)));

    // R7: single-ended state moves only as its clock falls
    p_se_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(se_state) |-> ($past(se_ph) && !se_ph));

    // R10: no power-down before straps are latched
    p_no_pd_before_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> captured);

endmodule

bind strap_pd_seq strap_pd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .captured  (captured),
    .sync_lo   (sync_lo),
    .strap_rb  (strap_rb),
    .pd_active (pd_active),
    .se_state  (se_state),
    .se_ph     (se_ph)
);

// File: tb/strap_pd_seq_tb.sv
module strap_pd_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NDIFF      = 2;
    localparam int LOCKT      = 8;
    localparam int DDIV       = 1;
    localparam int SDIV       = 2;
    localparam int WD_LIMIT   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin = 1'b1;
    logic             fa = 1'b0, fb = 1'b0, fc = 1'b0, tbl = 1'b0;
    logic [NDIFF-1:0] mode = '0;
    logic [1:0]       freq_code;
    logic             freq_rsvd;
    logic [3:0]       strap_rb;
    logic             pd_active;
    logic             se_clk;
    logic [1:0]       se_state;
    logic [NDIFF-1:0] diff_t, diff_c, diff_t_oe, diff_c_oe;
    logic [2*NDIFF-1:0] diff_state;

    strap_pd_seq #(.N_DIFF(NDIFF), .LOCK_TICKS(LOCKT), .DIFF_DIV(DDIV), .SE_DIV(SDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .pg_pd_pin(pin),
        .strap_fa(fa), .strap_fb(fb), .strap_fc(fc), .strap_tbl(tbl),
        .pd_tri_mode(mode), .freq_code(freq_code), .freq_rsvd(freq_rsvd),
        .strap_rb(strap_rb), .pd_active(pd_active), .se_clk(se_clk),
        .se_state(se_state), .diff_t(diff_t), .diff_c(diff_c),
        .diff_t_oe(diff_t_oe), .diff_c_oe(diff_c_oe), .diff_state(diff_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit run_cmp  = 0;
    int cyc      = 0;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // ---------------- behavioural reference ----------------
    int   m_hist[$];
    bit   m_cap, m_seen;
    int   m_rb, m_phase, m_cnt;   // phase: 0 running, 1 down, 2 settling
    int   g_cnt[3], g_ph[3], g_st[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = '{1, 1};
            m_cap = 0; m_seen = 0; m_rb = 0; m_phase = 0; m_cnt = 0;
            for (int g = 0; g < 3; g++) begin g_cnt[g] = 0; g_ph[g] = 0; g_st[g] = 0; end
        end else begin
            bit old_cap, old_pd, hi, req, qual;
            old_cap = m_cap;
            old_pd  = (m_phase != 0);
            hi      = (m_hist[1] == 1);
            for (int g = 0; g < 3; g++) begin
                int div, want;
                div  = (g == 0) ? SDIV : DDIV;
                want = !old_pd ? 0 : (g == 0) ? 1 : (mode[g-1] ? 3 : 2);
                if (g_cnt[g] == div - 1) begin
                    g_cnt[g] = 0;
                    if (g_ph[g] == 1) g_st[g] = want;
                    g_ph[g] = 1 - g_ph[g];
                end else g_cnt[g]++;
            end
            if (!m_cap && !hi) begin
                m_cap = 1;
                m_rb  = {tbl, fc, fb, fa};
            end
            req    = old_cap && hi;
            qual   = req && m_seen;
            m_seen = req;
            case (m_phase)
                0: if (qual) m_phase = 1;
                1: if (!hi) begin m_phase = 2; m_cnt = LOCKT - 1; end
                default: begin
                    if (qual) m_phase = 1;
                    else if (m_cnt == 0) m_phase = 0;
                    else m_cnt--;
                end
            endcase
            m_hist = '{int'(pin), m_hist[0]};
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (run_cmp && !done) begin
            chk("R6 pd_active per cycle", pd_active, (m_phase != 0));
            chk("R2 strap_rb per cycle", strap_rb, m_rb);
            chk("R7 se_state per cycle", se_state, g_st[0]);
            chk("R7 se_clk per cycle", se_clk, (g_st[0] == 0) ? g_ph[0] : 0);
            for (int i = 0; i < NDIFF; i++) begin
                int st, ph;
                st = g_st[i+1]; ph = g_ph[i+1];
                chk("R8 diff_state per cycle", diff_state[2*i +: 2], st);
                chk("R8 diff_t per cycle", diff_t[i], (st == 0) ? ph : (st == 2));
                chk("R8 diff_c per cycle", diff_c[i], (st == 0) ? 1 - ph : 0);
                chk("R8 diff_t_oe per cycle", diff_t_oe[i], st != 3);
                chk("R8 diff_c_oe per cycle", diff_c_oe[i], st == 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; pin = 1;
        tick(2);
        rst_n = 1;
    endtask

    function automatic void exp_freq(logic [3:0] v, output int code, output int rs);
        code = 0; rs = 0;
        if (!v[3]) begin
            case (v[2:0])
                3'b101: code = 0;
                3'b001: code = 1;
                3'b010: code = 2;
                3'b000: code = 3;
                default: rs = 1;
            endcase
        end else begin
            case (v[1:0])
                2'b00: code = 0;
                2'b01: code = 1;
                2'b10: code = 2;
                default: rs = 1;
            endcase
        end
    endfunction

    initial begin
        do_reset();
        run_cmp = 1;
        tick(1);
        // R1 reset state
        chk("R1 pd_active", pd_active, 0);
        chk("R1 se_state", se_state, 0);
        chk("R1 diff_state", diff_state, 0);
        chk("R1 strap_rb", strap_rb, 0);

        // R10 pin high before capture has no effect
        pin = 1; tick(10);
        chk("R10 pd_active", pd_active, 0);
        chk("R10 strap_rb", strap_rb, 0);

        // R2 R4 R5 every strap combination
        for (int v = 0; v < 16; v++) begin
            int ec, er;
            do_reset();
            {tbl, fc, fb, fa} = 4'(v);
            tick(1);
            pin = 0;
            tick(2);
            chk("R2 not yet latched", strap_rb, 0);
            tick(1);
            chk("R2 latched straps", strap_rb, v);
            exp_freq(4'(v), ec, er);
            chk(v < 8 ? "R4 freq_code" : "R5 freq_code", freq_code, ec);
            chk(v < 8 ? "R4 freq_rsvd" : "R5 freq_rsvd", freq_rsvd, er);
        end

        // R3 strap changes after capture ignored (rb = 1111 now)
        {tbl, fc, fb, fa} = 4'b0000;
        tick(4);
        chk("R3 strap_rb frozen", strap_rb, 15);
        chk("R3 freq_rsvd frozen", freq_rsvd, 1);

        // R6 single-cycle pulse ignored
        pin = 1; tick(1); pin = 0; tick(6);
        chk("R6 pulse ignored", pd_active, 0);
        chk("R3 strap_rb after pulse", strap_rb, 15);

        // R6 qualification timing, R7 R8 held states
        mode = 2'b10;
        pin = 1;
        tick(3);
        chk("R6 not yet active", pd_active, 0);
        tick(1);
        chk("R6 active at k+3", pd_active, 1);
        tick(8);
        chk("R7 se held low", se_state, 1);
        chk("R7 se_clk low", se_clk, 0);
        chk("R8 diff0 high state", diff_state[1:0], 2);
        chk("R8 diff0 true high", diff_t[0], 1);
        chk("R8 diff0 comp off", diff_c_oe[0], 0);
        chk("R8 diff1 tri state", diff_state[3:2], 3);
        chk("R8 diff1 true off", diff_t_oe[1], 0);
        chk("R3 strap_rb in pd", strap_rb, 15);

        // R9 release after lock delay
        pin = 0;
        tick(LOCKT + 2);
        chk("R9 still settling", pd_active, 1);
        tick(1);
        chk("R9 released", pd_active, 0);
        tick(8);
        chk("R9 se running again", se_state, 0);
        chk("R9 diff running again", diff_state, 0);

        // R9 re-request landing on lock expiry
        pin = 1; tick(10);
        chk("R9 back in pd", pd_active, 1);
        pin = 0;
        tick(LOCKT - 1);
        pin = 1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            chk("R9 collision keeps pd", pd_active, 1);
        end

        // R8 drive mode change while down
        mode = 2'b01;
        tick(4);
        chk("R8 diff0 now tri", diff_state[1:0], 3);
        chk("R8 diff1 now high", diff_state[3:2], 2);
        chk("R8 diff1 comp undriven", diff_c_oe[1], 0);

        pin = 0;
        tick(LOCKT + 10);
        chk("R9 final release", pd_active, 0);
        summary();
    end

endmodule